// File: doc/BRIEF.md
# Serial Channel Interrupt and DMA Request Generator

This block turns the status flags of a set of serial channels into the requests that the interrupt controller and the DMA controller consume. For each channel it watches the transmit-buffer-empty, transmission-finished, reception-finished and receive-error flags. It qualifies them with the channel's transmit and receive enable bits and with its clock-source choice. From this it raises one-cycle DMA transfer requests and sticky interrupt pending flags.

Software picks, per channel and per direction, which status event counts as the interrupt source. It masks each source with an interrupt-enable bit and acknowledges pending flags with a write-one-to-clear. Channels are paired: the two channels of a pair drive one shared interrupt line, and that line is the OR of the enabled pending flags of both channels.

Top module: `sio_irq_dma_gen`

## Requirements
- R1: With the transmit source select at 0 (buffer empty), a rising edge of that channel's `tx_empty` while `tx_en` is high sets its transmit pending flag. That flag is `pending` bit 2c for channel c, and it is visible in the cycle after the edge.
- R2: With the transmit source select at 1 (transmission finished), a rising edge of `tx_done` sets the transmit pending flag only when `int_clk` is 1 (internal clock). With `int_clk` at 0 it sets nothing.
- R3: With the receive source select at 0 (reception finished), a rising edge of `rx_full` sets the receive pending flag, `pending` bit 2c+1. With the select at 1 (error), a rising edge of `rx_err` sets it instead. Either edge counts only while `rx_en` is high.
- R4: A pending flag stays set until a cycle with `clr_we` high and the matching `clr_mask` bit at 1. The flag reads 0 from the next cycle on. Mask bits at 0 leave their flags untouched.
- R5: `irq[g]` is high exactly when a pending flag of channel 2g or 2g+1 is set and that flag's interrupt-enable bit is 1. A group's line never reflects another group's channels.
- R6: Raising `tx_en` while `tx_empty` is already 1 and the source select is 0 sets the transmit pending flag one cycle later.
- R7: `tx_dma_req[c]` pulses high for exactly one cycle, one cycle after `tx_en & tx_empty` rises. It stays low while that condition holds.
- R8: `rx_dma_req[c]` pulses high for exactly one cycle, one cycle after `rx_en & rx_full & ~rx_err` rises. No pulse is produced for a frame whose `rx_err` is high.
- R9: A cycle with `tx_en` (or `rx_en`) at 0 clears that direction's pending flag on the next cycle. While the bit stays at 0, no new flag or DMA request is produced for that direction.
- R10: After reset, all pending flags, interrupt lines and DMA requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_empty | input | NUM_CH | Transmit buffer empty flag per channel |
| tx_done | input | NUM_CH | Transmission finished flag per channel |
| rx_full | input | NUM_CH | Receive buffer full (reception finished) per channel |
| rx_err | input | NUM_CH | Receive error on the current frame per channel |
| tx_en | input | NUM_CH | Transmit enable per channel |
| rx_en | input | NUM_CH | Receive enable per channel |
| int_clk | input | NUM_CH | 1 = channel runs on internal clock |
| tx_src_sel | input | NUM_CH | Transmit interrupt source: 0 buffer empty, 1 finished |
| rx_src_sel | input | NUM_CH | Receive interrupt source: 0 finished, 1 error |
| tx_irq_en | input | NUM_CH | Transmit interrupt enable per channel |
| rx_irq_en | input | NUM_CH | Receive interrupt enable per channel |
| clr_we | input | 1 | Write strobe for the pending clear |
| clr_mask | input | 2*NUM_CH | Write-one-to-clear mask, bit 2c tx, bit 2c+1 rx |
| pending | output | 2*NUM_CH | Pending flags, bit 2c tx, bit 2c+1 rx |
| tx_dma_req | output | NUM_CH | One-cycle transmit DMA request |
| rx_dma_req | output | NUM_CH | One-cycle receive DMA request |
| irq | output | NUM_GRP | Combined interrupt per pair of channels |

## Verification
The bench enables transmission while the buffer is already empty. A design that detects only flag edges would miss this interrupt, and one that treats the DMA request as a level would hold the request high for many cycles. It selects the transmission-finished source with an external clock, where a wrong design raises a spurious flag. It also delivers a frame with an error, which a careless design would still hand to DMA. Finally it drops an enable bit with a flag pending and sets a pending flag with its interrupt masked, to catch stale flags and leakage onto the shared line of the other group.

// File: rtl/sio_req_pkg.sv
package sio_req_pkg;

    // transmit interrupt source codes
    localparam logic TXSRC_EMPTY = 1'b0;
    localparam logic TXSRC_DONE  = 1'b1;
    // receive interrupt source codes
    localparam logic RXSRC_FULL  = 1'b0;
    localparam logic RXSRC_ERR   = 1'b1;

    typedef struct packed {
        logic rx;
        logic tx;
    } dir_pair_t;

    function automatic logic rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/sio_chan_req.sv
module sio_chan_req
    import sio_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_empty,
    input  logic      tx_done,
    input  logic      rx_full,
    input  logic      rx_err,
    input  logic      tx_en,
    input  logic      rx_en,
    input  logic      int_clk,
    input  logic      sel_tx,
    input  logic      sel_rx,
    input  dir_pair_t clr,
    output dir_pair_t pend,
    output dir_pair_t dma
);

    dir_pair_t irq_cond, irq_cond_q;
    dir_pair_t dma_cond, dma_cond_q;
    dir_pair_t pend_q, dma_q;

    always_comb begin
        irq_cond.tx = tx_en & ((sel_tx == TXSRC_DONE) ? (tx_done & int_clk) : tx_empty);
        irq_cond.rx = rx_en & ((sel_rx == RXSRC_ERR) ? rx_err : rx_full);
        dma_cond.tx = tx_en & tx_empty;
        dma_cond.rx = rx_en & rx_full & ~rx_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_cond_q <= '0;
            dma_cond_q <= '0;
            pend_q     <= '0;
            dma_q      <= '0;
        end else begin
            irq_cond_q <= irq_cond;
            dma_cond_q <= dma_cond;
            dma_q.tx   <= rise(dma_cond.tx, dma_cond_q.tx);
            dma_q.rx   <= rise(dma_cond.rx, dma_cond_q.rx);
            pend_q.tx  <= tx_en ? ((pend_q.tx & ~clr.tx) | rise(irq_cond.tx, irq_cond_q.tx)) : 1'b0;
            pend_q.rx  <= rx_en ? ((pend_q.rx & ~clr.rx) | rise(irq_cond.rx, irq_cond_q.rx)) : 1'b0;
        end
    end

    assign pend = pend_q;
    assign dma  = dma_q;

    // R7: transmit DMA request lasts a single cycle
    a_r7_tx_dma_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dma_q.tx |=> !dma_q.tx);

    // R8: receive DMA request lasts a single cycle and never follows an errored frame
    a_r8_rx_dma_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dma_q.rx |=> !dma_q.rx);
    a_r8_no_dma_on_error: assert property (@(posedge clk) disable iff (rst)
        (rx_err || !rx_en) |=> !dma_q.rx);

    // R9: a cleared enable bit empties the pending flag of that direction
    a_r9_tx_off_drops: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !pend_q.tx);
    a_r9_rx_off_drops: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !pend_q.rx);

    // R4: an enabled, uncleared flag holds
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (pend_q.tx && tx_en && !clr.tx) |=> pend_q.tx);

    // R2: finished-source flag cannot appear with an external clock
    a_r2_ext_clk_silent: assert property (@(posedge clk) disable iff (rst)
        (sel_tx == TXSRC_DONE && !int_clk && !pend_q.tx) |=> !pend_q.tx);

endmodule

// File: rtl/sio_grp_irq.sv
module sio_grp_irq #(
    parameter int CH_PER_GRP = 2
) (
    input  logic [CH_PER_GRP-1:0] pend_tx,
    input  logic [CH_PER_GRP-1:0] pend_rx,
    input  logic [CH_PER_GRP-1:0] en_tx,
    input  logic [CH_PER_GRP-1:0] en_rx,
    output logic                  irq
);

    always_comb begin
        irq = |{(pend_tx & en_tx), (pend_rx & en_rx)};
    end

endmodule

// File: rtl/sio_irq_dma_gen.sv
module sio_irq_dma_gen
    import sio_req_pkg::*;
#(
    parameter int NUM_GRP    = 2,
    parameter int CH_PER_GRP = 2,
    localparam int NUM_CH    = NUM_GRP * CH_PER_GRP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   tx_empty,
    input  logic [NUM_CH-1:0]   tx_done,
    input  logic [NUM_CH-1:0]   rx_full,
    input  logic [NUM_CH-1:0]   rx_err,
    input  logic [NUM_CH-1:0]   tx_en,
    input  logic [NUM_CH-1:0]   rx_en,
    input  logic [NUM_CH-1:0]   int_clk,
    input  logic [NUM_CH-1:0]   tx_src_sel,
    input  logic [NUM_CH-1:0]   rx_src_sel,
    input  logic [NUM_CH-1:0]   tx_irq_en,
    input  logic [NUM_CH-1:0]   rx_irq_en,
    input  logic                clr_we,
    input  logic [2*NUM_CH-1:0] clr_mask,
    output logic [2*NUM_CH-1:0] pending,
    output logic [NUM_CH-1:0]   tx_dma_req,
    output logic [NUM_CH-1:0]   rx_dma_req,
    output logic [NUM_GRP-1:0]  irq
);

    logic [NUM_CH-1:0] pend_tx, pend_rx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dir_pair_t clr_c, pend_c, dma_c;

        assign clr_c.tx = clr_we & clr_mask[2*c];
        assign clr_c.rx = clr_we & clr_mask[2*c+1];

        sio_chan_req u_ch (
            .clk      (clk),
            .rst      (rst),
            .tx_empty (tx_empty[c]),
            .tx_done  (tx_done[c]),
            .rx_full  (rx_full[c]),
            .rx_err   (rx_err[c]),
            .tx_en    (tx_en[c]),
            .rx_en    (rx_en[c]),
            .int_clk  (int_clk[c]),
            .sel_tx   (tx_src_sel[c]),
            .sel_rx   (rx_src_sel[c]),
            .clr      (clr_c),
            .pend     (pend_c),
            .dma      (dma_c)
        );

        assign pend_tx[c]      = pend_c.tx;
        assign pend_rx[c]      = pend_c.rx;
        assign pending[2*c]    = pend_c.tx;
        assign pending[2*c+1]  = pend_c.rx;
        assign tx_dma_req[c]   = dma_c.tx;
        assign rx_dma_req[c]   = dma_c.rx;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        sio_grp_irq #(.CH_PER_GRP(CH_PER_GRP)) u_grp (
            .pend_tx (pend_tx[g*CH_PER_GRP +: CH_PER_GRP]),
            .pend_rx (pend_rx[g*CH_PER_GRP +: CH_PER_GRP]),
            .en_tx   (tx_irq_en[g*CH_PER_GRP +: CH_PER_GRP]),
            .en_rx   (rx_irq_en[g*CH_PER_GRP +: CH_PER_GRP]),
            .irq     (irq[g])
        );

        // R5: line is quiet when every enable of the pair is off
        a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
            (tx_irq_en[g*CH_PER_GRP +: CH_PER_GRP] == '0 &&
             rx_irq_en[g*CH_PER_GRP +: CH_PER_GRP] == '0) |-> !irq[g]);
    end

endmodule

// File: tb/sim_sio_irq_dma_gen.sv
`timescale 1ns/100ps
module sim_sio_irq_dma_gen;

    localparam int NCH = 4;
    localparam int NG  = 2;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] tx_empty, tx_done, rx_full, rx_err, tx_en, rx_en, int_clk;
    logic [NCH-1:0] tx_src_sel, rx_src_sel, tx_irq_en, rx_irq_en;
    logic clr_we;
    logic [2*NCH-1:0] clr_mask, pending;
    logic [NCH-1:0] tx_dma_req, rx_dma_req;
    logic [NG-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sio_irq_dma_gen u0 (
        .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_done(tx_done),
        .rx_full(rx_full), .rx_err(rx_err), .tx_en(tx_en), .rx_en(rx_en),
        .int_clk(int_clk), .tx_src_sel(tx_src_sel), .rx_src_sel(rx_src_sel),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .clr_we(clr_we),
        .clr_mask(clr_mask), .pending(pending), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        tx_empty = '0; tx_done = '0; rx_full = '0; rx_err = '0;
        tx_en = '0; rx_en = '0; int_clk = '0;
        tx_src_sel = '0; rx_src_sel = '0; tx_irq_en = '0; rx_irq_en = '0;
        clr_we = 1'b0; clr_mask = '0;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 pending", 32'(pending), 0);
        chk("R10 irq", 32'(irq), 0);
        chk("R10 dma", 32'({tx_dma_req, rx_dma_req}), 0);
    endtask

    task automatic t_tx_enable();
        do_reset();
        tx_empty[0] = 1; tx_irq_en[0] = 1;
        cyc(2);
        chk("R9 no flag while disabled", 32'(pending), 0);
        tx_en[0] = 1;
        cyc(1);
        chk("R6 pending on enable", 32'(pending[0]), 1);
        chk("R7 tx dma pulse", 32'(tx_dma_req), 32'h1);
        chk("R5 irq grp0", 32'(irq), 32'h1);
        cyc(1);
        chk("R7 tx dma drops", 32'(tx_dma_req), 0);
        chk("R4 pending held", 32'(pending[0]), 1);
        clr_we = 1; clr_mask = 8'h02;
        cyc(1);
        chk("R4 other bit untouched", 32'(pending[0]), 1);
        clr_mask = 8'h01;
        cyc(1);
        clr_we = 0; clr_mask = '0;
        chk("R4 cleared", 32'(pending), 0);
        tx_empty[0] = 0;
        cyc(1);
        tx_empty[0] = 1;
        cyc(1);
        chk("R1 empty edge sets", 32'(pending[0]), 1);
        chk("R7 second dma pulse", 32'(tx_dma_req), 32'h1);
    endtask

    task automatic t_tx_done();
        do_reset();
        tx_src_sel[1] = 1; tx_en[1] = 1; int_clk[1] = 0; tx_irq_en[1] = 1;
        cyc(1);
        tx_done[1] = 1;
        cyc(2);
        chk("R2 external clock silent", 32'(pending[2]), 0);
        tx_done[1] = 0; int_clk[1] = 1;
        cyc(1);
        tx_done[1] = 1;
        cyc(1);
        chk("R2 internal clock sets", 32'(pending[2]), 1);
        chk("R5 grp0 from ch1", 32'(irq), 32'h1);
    endtask

    task automatic t_rx();
        do_reset();
        rx_en[2] = 1; rx_irq_en[2] = 1;
        cyc(1);
        rx_full[2] = 1;
        cyc(1);
        chk("R3 finished source", 32'(pending[5]), 1);
        chk("R8 rx dma pulse", 32'(rx_dma_req), 32'h4);
        chk("R5 grp1 only", 32'(irq), 32'h2);
        cyc(1);
        chk("R8 rx dma drops", 32'(rx_dma_req), 0);
        rx_full[2] = 0; rx_src_sel[2] = 1;
        clr_we = 1; clr_mask = 8'h20;
        cyc(1);
        clr_we = 0; clr_mask = '0;
        chk("R4 rx cleared", 32'(pending), 0);
        rx_full[2] = 1; rx_err[2] = 1;
        cyc(1);
        chk("R8 no dma on error", 32'(rx_dma_req), 0);
        chk("R3 error source", 32'(pending[5]), 1);
        cyc(1);
        chk("R8 still no dma", 32'(rx_dma_req), 0);
    endtask

    task automatic t_mask_and_disable();
        do_reset();
        tx_empty[1] = 1; tx_irq_en[1] = 0;
        tx_en[1] = 1;
        cyc(1);
        chk("R5 masked flag pending", 32'(pending), 32'h04);
        chk("R5 masked irq low", 32'(irq), 0);
        tx_irq_en[1] = 1;
        cyc(1);
        chk("R5 unmasked irq", 32'(irq), 32'h1);
        tx_en[1] = 0;
        cyc(1);
        chk("R9 disable drops flag", 32'(pending), 0);
        chk("R9 irq drops", 32'(irq), 0);
        tx_empty[1] = 0;
        cyc(1);
        tx_empty[1] = 1;
        cyc(1);
        chk("R9 no new flag", 32'(pending), 0);
        chk("R9 no dma while off", 32'(tx_dma_req), 0);
        rx_full[3] = 1;
        cyc(1);
        chk("R9 rx off no dma", 32'(rx_dma_req), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_tx_enable();
        t_tx_done();
        t_rx();
        t_mask_and_disable();
        finish_run();
    end

endmodule